// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Vector Return

This block gathers a small set of interrupt conditions raised by a serial channel. It forms one active-low request line for an external interrupt controller. A mask register decides which conditions count. A status register shows the conditions that are both raised and enabled. The request line goes low whenever at least one enabled condition is raised.

When the controller acknowledges the interrupt, the block answers in one of two ways, chosen by a control bit:
- It places a programmable 8-bit vector on its data output.
- It raises an autovector strobe, which tells the controller to supply the vector itself.

Software reaches the mask, vector and control registers over a simple select/write bus. Read data comes back one cycle after the request.

Top module: `irq_vector_agg`

## Requirements
- R1: After reset the mask is 0, the vector register holds 0x0F, the autovector bit is 0, `irq_n_o` is high, and `data_en_o` and `avec_o` are low.
- R2: `irq_n_o` is low in the same cycle that any bit of `cond_i & mask` is 1. It is high otherwise.
- R3: Reading address 0 returns the status, `cond_i & mask`, as it stood in the request cycle. Bits at and above NUM_SRC read 0.
- R4: Address 1 is the mask. A write stores the low NUM_SRC bits. A read returns them zero-extended.
- R5: Address 2 is the 8-bit vector register. A write stores it and a read returns it.
- R6: Address 3 is control. Bit 0 selects autovector (1) or vectoring (0). The other bits read 0.
- R7: A read (`sel_i`=1, `wr_i`=0) makes `data_en_o` high for exactly the next cycle, with the read value on `data_o`.
- R8: When `iack_i` is high with vectoring selected, `data_en_o` is high and `data_o` holds the vector for exactly the next cycle. `avec_o` stays low.
- R9: When `iack_i` is high with autovector selected, `avec_o` is high for exactly the next cycle. `data_en_o` stays low and `data_o` is 0.
- R10: If `iack_i` and a read request arrive in the same cycle, the acknowledge wins and the read is dropped. A write in the same cycle still takes effect, but the acknowledge returns the register value held before that write.
- R11: `data_o` is 0 whenever `data_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | NUM_SRC | Raw interrupt conditions |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| data_o | output | 8 | Read data or vector |
| data_en_o | output | 1 | data_o valid for this cycle |
| avec_o | output | 1 | Autovector request strobe |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench checks the following corner cases:
- **Masked conditions held high.** A design that ignored the mask would pull the request low and show bits in the status read.
- **Acknowledge colliding with a read or a write.** A design that gave the read priority would return register data instead of the vector. One that forwarded the fresh write would return the new vector instead of the old one.
- **Autovector and vector cycles.** A design that held its strobes for more than one cycle, or drove stale data outside a valid cycle, would be caught by the pulse-width checks and the zero-data checks.

// File: rtl/irq_vector_agg.sv
module irq_vector_agg #(
  parameter int NUM_SRC = 4,
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cond_i,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               iack_i,
  output logic [7:0]         data_o,
  output logic               data_en_o,
  output logic               avec_o,
  output logic               irq_n_o
);
  localparam logic [1:0] A_STAT = 2'd0, A_MASK = 2'd1, A_VEC = 2'd2, A_CTRL = 2'd3;

  logic [NUM_SRC-1:0] mask_q;
  logic [7:0]         vec_q;
  logic               auto_q;
  logic [7:0]         rd_val;

  wire [NUM_SRC-1:0] pend = cond_i & mask_q;
  assign irq_n_o = ~|pend;

  always_comb begin
    case (addr_i)
      A_STAT:  rd_val = 8'(pend);
      A_MASK:  rd_val = 8'(mask_q);
      A_VEC:   rd_val = vec_q;
      default: rd_val = {7'd0, auto_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      vec_q  <= VEC_RST;
      auto_q <= 1'b0;
    end else if (sel_i && wr_i) begin
      case (addr_i)
        A_MASK:  mask_q <= wdata_i[NUM_SRC-1:0];
        A_VEC:   vec_q  <= wdata_i;
        A_CTRL:  auto_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o    <= '0;
      data_en_o <= 1'b0;
      avec_o    <= 1'b0;
    end else begin
      data_o    <= '0;
      data_en_o <= 1'b0;
      avec_o    <= 1'b0;
      if (iack_i) begin
        if (auto_q) avec_o <= 1'b1;
        else begin
          data_en_o <= 1'b1;
          data_o    <= vec_q;
        end
      end else if (sel_i && !wr_i) begin
        data_en_o <= 1'b1;
        data_o    <= rd_val;
      end
    end
  end

  // R2
  a_r2_quiet_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_i & mask_q) == '0) |-> irq_n_o);
  // R3
  a_r3_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && !iack_i && addr_i == A_STAT) |=> (data_en_o && data_o == 8'($past(cond_i & mask_q))));
  // R8
  a_r8_vector_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && !auto_q) |=> (data_en_o && !avec_o && data_o == $past(vec_q)));
  // R9
  a_r9_autovector_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && auto_q) |=> (avec_o && !data_en_o));
  // R11
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !data_en_o |-> (data_o == 8'd0));
  // R7
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_i && !(sel_i && !wr_i)) |=> (!data_en_o && !avec_o));
endmodule

// File: tb/irq_vector_agg_tb_top.sv
module irq_vector_agg_tb_top;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] cond_i = '0;
  logic sel_i = 0, wr_i = 0, iack_i = 0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] data_o;
  logic data_en_o, avec_o, irq_n_o;
  int checks = 0, errors = 0;
  logic [N-1:0] m_mask = '0;
  logic [7:0] m_vec = 8'h0F;
  logic m_auto = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_agg #(.NUM_SRC(N)) dut_i (.clk(clk), .rst_n(rst_n), .cond_i(cond_i), .sel_i(sel_i),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .iack_i(iack_i), .data_o(data_o),
    .data_en_o(data_en_o), .avec_o(avec_o), .irq_n_o(irq_n_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return 8'(cond_i & m_mask);
      2'd1: return 8'(m_mask);
      2'd2: return m_vec;
      default: return {7'd0, m_auto};
    endcase
  endfunction

  // Drive one cycle at the falling edge, check the registered result after the rising edge.
  task automatic op(input bit s, input bit w, input logic [1:0] a, input logic [7:0] d,
                    input bit ack, input logic [N-1:0] c);
    logic [7:0] e_data; bit e_en, e_av;
    @(negedge clk);
    cond_i = c; sel_i = s; wr_i = w; addr_i = a; wdata_i = d; iack_i = ack;
    #1;
    chk(irq_n_o == ((c & m_mask) == '0), "R2 irq_n", irq_n_o, ((c & m_mask) == '0));
    e_data = 0; e_en = 0; e_av = 0;
    if (ack) begin
      if (m_auto) e_av = 1; else begin e_en = 1; e_data = m_vec; end
    end else if (s && !w) begin
      e_en = 1; e_data = exp_read(a);
    end
    @(posedge clk);
    if (s && w) begin
      case (a)
        2'd1: m_mask = d[N-1:0];
        2'd2: m_vec = d;
        2'd3: m_auto = d[0];
        default: ;
      endcase
    end
    #1;
    chk(data_en_o == e_en, ack ? "R8/R10 data_en" : "R7 data_en", data_en_o, e_en);
    chk(avec_o == e_av, "R9 avec", avec_o, e_av);
    chk(data_o == e_data, ack ? (m_auto ? "R9 data" : "R8 data") :
        (a == 0 ? "R3 status" : (a == 1 ? "R4 mask" : (a == 2 ? "R5 vector" : "R6 ctrl"))),
        data_o, e_data);
    if (!e_en) chk(data_o == 0, "R11 idle data", data_o, 0);
  endtask

  task automatic idle(input logic [N-1:0] c);
    op(0, 0, 0, 0, 0, c);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(irq_n_o == 1, "R1 irq_n", irq_n_o, 1);
    chk(data_en_o == 0 && avec_o == 0, "R1 strobes", {data_en_o, avec_o}, 0);
    @(negedge clk); rst_n = 1;
    // R1 register reset values
    op(1, 0, 2'd1, 0, 0, '1);
    op(1, 0, 2'd2, 0, 0, '1);
    op(1, 0, 2'd3, 0, 0, '1);
    op(1, 0, 2'd0, 0, 0, '1);
    // R4 mask upper bits dropped; R2 masked behaviour
    op(1, 1, 2'd1, 8'hF5, 0, 4'b1010);
    op(1, 0, 2'd1, 0, 0, 4'b1010);
    op(1, 0, 2'd0, 0, 0, 4'b1111);
    idle(4'b0100);
    // R6 ctrl upper bits read 0
    op(1, 1, 2'd3, 8'hFE, 0, 0);
    op(1, 0, 2'd3, 0, 0, 0);
    // R8 vector ack with reset vector
    op(0, 0, 0, 0, 1, 4'b0001);
    // R5 vector write
    op(1, 1, 2'd2, 8'hA7, 0, 0);
    op(1, 0, 2'd2, 0, 0, 0);
    // R10 ack with colliding read, then with colliding vector write
    op(1, 0, 2'd1, 0, 1, 0);
    op(1, 1, 2'd2, 8'h3C, 1, 0);
    op(0, 0, 0, 0, 1, 0);
    // R9 autovector
    op(1, 1, 2'd3, 8'h01, 0, 0);
    op(0, 0, 0, 0, 1, 4'b0001);
    idle(0);
    op(1, 0, 2'd0, 0, 1, 4'b0101);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0], r[1], r[3:2], r[15:8], (r[6:4] == 0), r[19:16]);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errors++; $display("FAIL watchdog expired"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule